// File: doc/BRIEF.md
# Descriptor RAM Indirect Access Port

This block gives software a narrow 32-bit register window onto a descriptor store that is wider than one bus word. A descriptor is several 32-bit words long: four words for the regular format and two for the compact format, chosen by a parameter. Software first writes a slot number into the address register. It then accesses the data register once per word, and a hidden word index moves forward by one on every access. The staged words reach the store only when the final word of a descriptor is written, so a half-written descriptor is never seen downstream.

The store is used as a ring. A descriptor is accepted only into the next free slot, and the count of held descriptors goes up by one. A consumer on the pop side takes descriptors out in order, oldest first. Reading a descriptor back starts at word index zero, which captures the whole slot. Later reads return the remaining words from that captured copy. Three sticky error flags record discarded or malformed accesses: a commit while the store is full, a commit aimed at the wrong slot, and an address change in the middle of a descriptor. Full and empty levels appear beside the flags in the status register. A read-only info register reports the format and the store depth.

Top module: `desc_ram_port`

## Requirements
- R1: The address register (select 0) reads back the slot address in bits 15:0, the current word index in bits 19:16, and zero in bits 31:20. A write to it loads bits 15:0 from the write data.
- R2: A write to the address register clears the word index to 0. Each read or write of the data register (select 1) advances the index by one, and the index wraps to 0 after the last word (index 3 for regular, index 1 for compact).
- R3: Data writes at every index except the last only stage words. The descriptor count, the pop outputs and the store contents do not change until the last word is written.
- R4: A data read at index 0 returns word 0 of the slot selected by the low log2(DEPTH) bits of the address, and captures the whole slot. A data read at index k returns word k of that capture.
- R5: A commit (a write of the last word) is accepted when the store is not full and the full 16-bit address equals the next free slot. The descriptor is then stored there, the count rises by one and the next free slot advances modulo DEPTH.
- R6: A commit attempted while the store holds DEPTH descriptors is discarded and sets status bit 0.
- R7: A commit attempted while the store is not full, to an address other than the next free slot (including an address that only matches in its low bits), is discarded and sets status bit 1.
- R8: A write to the address register while the word index is not 0 sets status bit 2.
- R9: Status bits 0 to 2 stay set until a status write (select 2) carries a 1 in that bit position. A 0 in a bit position of that write leaves the flag unchanged.
- R10: Status bit 3 reads 1 when the count equals DEPTH, and bit 4 reads 1 when the count is 0. Bits 31:5 read 0, and writes to bits 31:3 have no effect.
- R11: The info register (select 3) reads the format bit (0 regular, 1 compact) in bit 0, DEPTH in bits 31:16, and zero elsewhere.
- R12: pop_valid is high exactly when the count is not 0. pop_data carries the oldest descriptor, with word 0 in bits 31:0. pop_ready with pop_valid removes that descriptor. An accepted commit and a pop in the same cycle leave the count unchanged.
- R13: After reset the count is 0, the word index and address are 0, and all error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored while reg_wr is high) |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 status, 3 info |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_rd |
| pop_ready | input | 1 | Consumer takes the oldest descriptor |
| pop_valid | output | 1 | A descriptor is available |
| pop_data | output | WORDS*32 | Oldest descriptor, word 0 in the low bits |

## Verification
The overlap that matters is a final-word data write that commits a descriptor in the same clock cycle as a pop from the consumer side. The bench provokes it on purpose by raising pop_ready in the cycle of the last data write. It also lets the overlap happen during the random phase, where the store is held near empty and near full. The bench judges the result by the count it sees afterwards through pop_valid, pop_data and the full and empty status bits. A full store followed by a commit in a pop cycle must still report an overflow, because the commit decision uses the count from before that cycle.

// File: rtl/desc_ram_pkg.sv
package desc_ram_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_STAT = 2'd2,
      SEL_INFO = 2'd3
   } reg_sel_e;

   localparam int ST_OVF   = 0;
   localparam int ST_ORDER = 1;
   localparam int ST_ALIGN = 2;
   localparam int ST_FULL  = 3;
   localparam int ST_EMPTY = 4;
   localparam int NUM_ERR  = 3;

   localparam int ADDR_W   = 16;
   localparam int IDX_FLD  = 4;

endpackage

// File: rtl/desc_ram_windex.sv
module desc_ram_windex #(
   parameter int WORDS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   addr_wr,
   input  logic                   data_wr,
   input  logic                   data_rd,
   input  logic [31:0]            wdata,
   input  logic [WORDS*32-1:0]    rd_line,
   output logic [$clog2(WORDS)-1:0] idx,
   output logic                   commit,
   output logic [WORDS*32-1:0]    commit_line,
   output logic [31:0]            rd_word
);
   localparam int IXW = $clog2(WORDS);

   logic [IXW-1:0] idx_q;
   logic           last;
   logic [31:0]    stage_q  [WORDS-1];
   logic [31:0]    shadow_q [WORDS];

   assign last = (idx_q == IXW'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (addr_wr) begin
         idx_q <= '0;
      end else if (data_wr || data_rd) begin
         idx_q <= last ? '0 : idx_q + 1'b1;
      end
   end

   // staging of all words but the last one
   for (genvar w = 0; w < WORDS - 1; w++) begin : g_stage
      always_ff @(posedge clk) begin
         if (data_wr && (idx_q == IXW'(w))) begin
            stage_q[w] <= wdata;
         end
      end
      assign commit_line[w*32 +: 32] = stage_q[w];
   end
   assign commit_line[WORDS*32-1 -: 32] = wdata;
   assign commit = data_wr && last;

   // read capture of the whole slot at index zero
   for (genvar w = 0; w < WORDS; w++) begin : g_shadow
      always_ff @(posedge clk) begin
         if (data_rd && (idx_q == '0)) begin
            shadow_q[w] <= rd_line[w*32 +: 32];
         end
      end
   end

   assign rd_word = (idx_q == '0) ? rd_line[31:0] : shadow_q[idx_q];
   assign idx     = idx_q;

   assert_idx_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_wr |=> (idx_q == '0));
   assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_wr && (data_wr || data_rd) && !last) |=> (idx_q == $past(idx_q) + 1'b1));
   assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(idx_q) < WORDS));

endmodule

// File: rtl/desc_ram_ring.sv
module desc_ram_ring #(
   parameter int DEPTH = 64,
   parameter int LINEW = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit,
   input  logic [15:0]              commit_addr,
   input  logic [LINEW-1:0]         commit_line,
   input  logic [$clog2(DEPTH)-1:0] rd_slot,
   output logic [LINEW-1:0]         rd_line,
   input  logic                     pop_ready,
   output logic                     pop_valid,
   output logic [LINEW-1:0]         pop_data,
   output logic                     full,
   output logic                     empty,
   output logic                     ovf_evt,
   output logic                     order_evt
);
   localparam int AW = $clog2(DEPTH);

   logic [LINEW-1:0] mem_q [DEPTH];
   logic [AW-1:0]    head_q, tail_q;
   logic [AW:0]      cnt_q;
   logic             slot_ok, accept, pop_fire;

   assign full      = (cnt_q == (AW+1)'(DEPTH));
   assign empty     = (cnt_q == '0);
   assign slot_ok   = (commit_addr == 16'(tail_q));
   assign ovf_evt   = commit && full;
   assign order_evt = commit && !full && !slot_ok;
   assign accept    = commit && !full && slot_ok;
   assign pop_valid = !empty;
   assign pop_fire  = pop_ready && !empty;

   always_ff @(posedge clk) begin
      if (accept) begin
         mem_q[tail_q] <= commit_line;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (accept) begin
            tail_q <= tail_q + 1'b1;
         end
         if (pop_fire) begin
            head_q <= head_q + 1'b1;
         end
         if (accept && !pop_fire) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (pop_fire && !accept) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign rd_line  = mem_q[rd_slot];
   assign pop_data = mem_q[head_q];

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= (AW+1)'(DEPTH)));
   assert_accept_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !pop_fire) |=> (cnt_q == $past(cnt_q) + (AW+1)'(1)));
   assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && full && !pop_fire) |=> $stable(cnt_q) && $stable(tail_q));
   assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   assert_pop_shrink_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_fire && !accept) |=> (cnt_q == $past(cnt_q) - (AW+1)'(1)));
   assert_both_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_fire && accept) |=> $stable(cnt_q));

endmodule

// File: rtl/desc_ram_errs.sv
module desc_ram_errs #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   logic [N-1:0] flags_q;

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q[i] <= 1'b0;
         end else if (set[i]) begin
            flags_q[i] <= 1'b1;
         end else if (clr[i]) begin
            flags_q[i] <= 1'b0;
         end
      end

      assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags_q[i]);
      assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!set[i] && !clr[i]) |=> $stable(flags_q[i]));
   end

   assign flags = flags_q;

endmodule

// File: rtl/desc_ram_port.sv
module desc_ram_port
   import desc_ram_pkg::*;
#(
   parameter bit DESC_TYPE = 1'b0,
   parameter int DEPTH     = 64,
   parameter int REG_WORDS = 4,
   parameter int CMP_WORDS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        pop_ready,
   output logic        pop_valid,
   output logic [(DESC_TYPE ? CMP_WORDS : REG_WORDS)*32-1:0] pop_data
);
   localparam int WORDS = DESC_TYPE ? CMP_WORDS : REG_WORDS;
   localparam int IXW   = $clog2(WORDS);
   localparam int AW    = $clog2(DEPTH);
   localparam int LINEW = WORDS * 32;

   // elaboration checks
   if (!(DEPTH == 64 || DEPTH == 128)) begin : g_bad_depth
      $error("desc_ram_port: DEPTH must be 64 or 128");
   end
   if (WORDS < 2 || WORDS > 16 || (1 << IXW) != WORDS) begin : g_bad_words
      $error("desc_ram_port: words per descriptor must be a power of two in 2..16");
   end

   reg_sel_e sel;
   logic     addr_wr, data_wr, data_rd, stat_wr;
   logic [ADDR_W-1:0] addr_q;
   logic [IXW-1:0]    idx;
   logic              commit;
   logic [LINEW-1:0]  commit_line, rd_line;
   logic [31:0]       rd_word;
   logic              full, empty, ovf_evt, order_evt, align_evt;
   logic [NUM_ERR-1:0] err_set, err_clr, err_flags;

   assign sel     = reg_sel_e'(reg_sel);
   assign addr_wr = reg_wr && (sel == SEL_ADDR);
   assign data_wr = reg_wr && (sel == SEL_DATA);
   assign stat_wr = reg_wr && (sel == SEL_STAT);
   assign data_rd = reg_rd && !reg_wr && (sel == SEL_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_wr) begin
         addr_q <= reg_wdata[ADDR_W-1:0];
      end
   end

   desc_ram_windex #(.WORDS(WORDS)) u_windex (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_wr     (addr_wr),
      .data_wr     (data_wr),
      .data_rd     (data_rd),
      .wdata       (reg_wdata),
      .rd_line     (rd_line),
      .idx         (idx),
      .commit      (commit),
      .commit_line (commit_line),
      .rd_word     (rd_word)
   );

   desc_ram_ring #(.DEPTH(DEPTH), .LINEW(LINEW)) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit),
      .commit_addr (addr_q),
      .commit_line (commit_line),
      .rd_slot     (addr_q[AW-1:0]),
      .rd_line     (rd_line),
      .pop_ready   (pop_ready),
      .pop_valid   (pop_valid),
      .pop_data    (pop_data),
      .full        (full),
      .empty       (empty),
      .ovf_evt     (ovf_evt),
      .order_evt   (order_evt)
   );

   assign align_evt        = addr_wr && (idx != '0);
   assign err_set[ST_OVF]   = ovf_evt;
   assign err_set[ST_ORDER] = order_evt;
   assign err_set[ST_ALIGN] = align_evt;
   assign err_clr           = stat_wr ? reg_wdata[NUM_ERR-1:0] : '0;

   desc_ram_errs #(.N(NUM_ERR)) u_errs (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .clr   (err_clr),
      .flags (err_flags)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_ADDR: reg_rdata = {12'b0, IDX_FLD'(idx), addr_q};
         SEL_DATA: reg_rdata = rd_word;
         SEL_STAT: reg_rdata = {27'b0, empty, full, err_flags};
         SEL_INFO: reg_rdata = {16'(DEPTH), 15'b0, DESC_TYPE};
         default:  reg_rdata = '0;
      endcase
   end

   assert_align_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      align_evt |=> err_flags[ST_ALIGN]);
   assert_no_stage_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !commit && !pop_ready) |=> $stable(pop_valid));
   assert_valid_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid == !empty);

endmodule

// File: tb/desc_ram_port_bench.sv
module desc_ram_port_bench;
   localparam int D = 64;
   localparam int W = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          pop_ready = 1'b0;
   logic          pop_valid;
   logic [W*32-1:0] pop_data;

   always #5 clk = ~clk;

   desc_ram_port u_desc_ram_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pop_ready (pop_ready),
      .pop_valid (pop_valid),
      .pop_data  (pop_data)
   );

   int checks = 0;
   int errors = 0;

   logic [31:0] m_mem   [D*W];
   bit          m_wr    [D];
   logic [31:0] m_stage [W];
   int          m_head = 0, m_tail = 0, m_cnt = 0, m_idx = 0;
   logic [15:0] m_addr = '0;
   logic [2:0]  m_flags = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status();
      return {27'b0, (m_cnt == 0), (m_cnt == D), m_flags};
   endfunction

   function automatic logic [31:0] exp_addr();
      return {12'b0, 4'(m_idx), m_addr};
   endfunction

   function automatic logic [31:0] exp_info();
      return {16'(D), 15'b0, 1'b0};
   endfunction

   task automatic bus_wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] sel, output logic [31:0] data);
      @(negedge clk);
      reg_rd = 1'b1; reg_sel = sel;
      #1 data = reg_rdata;
      @(posedge clk);
      #1 reg_rd = 1'b0;
   endtask

   task automatic set_addr(input logic [15:0] a);
      bus_wr(2'd0, {$urandom()} & 32'hFFFF_0000 | {16'b0, a});
      if (m_idx != 0) m_flags[2] = 1'b1;
      m_idx = 0;
      m_addr = a;
   endtask

   task automatic m_commit(input logic [31:0] w);
      if (m_cnt == D) begin
         m_flags[0] = 1'b1;
      end else if (m_addr != 16'(m_tail)) begin
         m_flags[1] = 1'b1;
      end else begin
         for (int k = 0; k < W - 1; k++) m_mem[m_tail*W + k] = m_stage[k];
         m_mem[m_tail*W + W - 1] = w;
         m_wr[m_tail] = 1'b1;
         m_tail = (m_tail + 1) % D;
         m_cnt++;
      end
   endtask

   task automatic put_word(input logic [31:0] w, input bit with_pop);
      int c0;
      c0 = m_cnt;
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = w;
      if (with_pop) pop_ready = 1'b1;
      @(posedge clk);
      #1 reg_wr = 1'b0; pop_ready = 1'b0;
      if (m_idx < W - 1) m_stage[m_idx] = w;
      else m_commit(w);
      if (with_pop && c0 > 0) begin
         m_head = (m_head + 1) % D;
         m_cnt--;
      end
      m_idx = (m_idx + 1) % W;
   endtask

   task automatic get_word(input string req);
      logic [31:0] v;
      bus_rd(2'd1, v);
      chk(req, v, m_mem[int'(m_addr % 16'(D))*W + m_idx]);
      m_idx = (m_idx + 1) % W;
   endtask

   task automatic write_desc(input logic [15:0] a, input bit pop_last);
      set_addr(a);
      for (int k = 0; k < W; k++) put_word($urandom(), pop_last && (k == W - 1));
   endtask

   task automatic read_desc(input logic [15:0] a);
      set_addr(a);
      for (int k = 0; k < W; k++) get_word("R4 data read");
   endtask

   task automatic do_pop();
      @(negedge clk);
      chk("R12 pop_valid", 32'(pop_valid), 32'(m_cnt != 0));
      if (m_cnt != 0) begin
         for (int k = 0; k < W; k++)
            chk("R12 pop_data word", pop_data[k*32 +: 32], m_mem[m_head*W + k]);
      end
      pop_ready = 1'b1;
      @(posedge clk);
      #1 pop_ready = 1'b0;
      if (m_cnt != 0) begin
         m_head = (m_head + 1) % D;
         m_cnt--;
      end
   endtask

   task automatic chk_status(input string req);
      logic [31:0] v;
      bus_rd(2'd2, v);
      chk(req, v, exp_status());
   endtask

   task automatic clear_flags(input logic [2:0] mask);
      bus_wr(2'd2, ({$urandom()} & 32'hFFFF_FFF8) | {29'b0, mask});
      m_flags = m_flags & ~mask;
   endtask

   task automatic pick_slot(output logic [15:0] a);
      int s;
      s = int'($urandom() % D);
      for (int n = 0; n < D && !m_wr[s]; n++) s = (s + 1) % D;
      a = 16'(s + D * int'($urandom() % 4));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [15:0] a;
      void'($urandom(32'h5EED_0C1D));
      for (int i = 0; i < D; i++) m_wr[i] = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R13 reset state, R10 empty, R11 info
      chk_status("R13 R10 reset status");
      bus_rd(2'd0, v); chk("R13 R1 reset address", v, exp_addr());
      bus_rd(2'd3, v); chk("R11 info", v, exp_info());
      @(negedge clk); chk("R13 R12 reset pop_valid", 32'(pop_valid), 32'd0);

      // R1 R2 R3 partial write stages only
      set_addr(16'h0000);
      put_word(32'hA0A0_0001, 1'b0);
      bus_rd(2'd0, v); chk("R1 R2 index after one word", v, exp_addr());
      put_word(32'hA0A0_0002, 1'b0);
      put_word(32'hA0A0_0003, 1'b0);
      chk_status("R3 no commit before last word");
      @(negedge clk); chk("R3 pop_valid still low", 32'(pop_valid), 32'd0);
      put_word(32'hA0A0_0004, 1'b0);
      bus_rd(2'd0, v); chk("R2 index wraps to zero", v, exp_addr());
      chk_status("R5 commit accepted");
      read_desc(16'h0000);
      read_desc(16'(D));

      // R8 address change mid-descriptor, R1 address field loading
      set_addr(16'h0001);
      put_word(32'h1234_5678, 1'b0);
      set_addr(16'hABCD);
      bus_rd(2'd0, v); chk("R1 address readback", v, exp_addr());
      chk_status("R8 mid-descriptor address write");
      clear_flags(3'b000);
      chk_status("R9 zero mask keeps flag");
      clear_flags(3'b100);
      chk_status("R9 clear by one");

      // R12 commit and pop in the same cycle
      write_desc(16'h0001, 1'b1);
      chk_status("R12 concurrent commit and pop status");
      do_pop();
      chk_status("R12 drained");

      // R7 wrong slot, including alias of next free slot
      write_desc(16'(m_tail + 3), 1'b0);
      chk_status("R7 wrong slot");
      clear_flags(3'b010);
      write_desc(16'(m_tail + D), 1'b0);
      chk_status("R7 aliased slot");
      clear_flags(3'b111);

      // random phases: write heavy, then pop heavy
      for (int ph = 0; ph < 2; ph++) begin
         for (int it = 0; it < 700; it++) begin
            int op;
            op = int'($urandom() % 10);
            if (ph == 1 && op < 4) op = op + 4;
            if (op < 4) begin
               write_desc(16'(m_tail), ($urandom() % 3) == 0);
            end else if (op == 4) begin
               write_desc(16'(m_tail + 1 + int'($urandom() % (D - 1))), 1'b0);
            end else if (op < 7) begin
               if (m_cnt != 0 || m_wr[0]) begin
                  pick_slot(a);
                  if (m_wr[int'(a % 16'(D))]) read_desc(a);
               end
            end else if (op < 9) begin
               do_pop();
            end else begin
               set_addr(16'(m_tail));
               for (int k = 0; k < 1 + int'($urandom() % (W - 1)); k++) put_word($urandom(), 1'b0);
               chk_status("R3 partial write status");
               set_addr(16'(m_tail));
            end
            chk_status("R5 R6 R7 R10 random status");
            if (($urandom() % 5) == 0) clear_flags(3'($urandom()));
         end
      end

      // R6 fill to full then overflow, with a pop in the overflow cycle
      clear_flags(3'b111);
      while (m_cnt < D) write_desc(16'(m_tail), 1'b0);
      chk_status("R10 full");
      write_desc(16'(m_tail), 1'b0);
      chk_status("R6 overflow when full");
      clear_flags(3'b001);
      write_desc(16'(m_tail), 1'b1);
      chk_status("R6 overflow despite pop in same cycle");
      read_desc(16'(m_tail));
      while (m_cnt > 0) do_pop();
      chk_status("R10 empty after drain");
      bus_rd(2'd3, v); chk("R11 info unchanged", v, exp_info());

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule